// File: doc/BRIEF.md
# Two-Port Four-Phase Request Merge

This block is a clocked controller that lets two passive four-phase handshake ports, `a` and `b`, share a single active four-phase port `c`. When one passive port raises its request, the block runs a complete return-to-zero handshake on `c` on its behalf. Each phase that `c` completes is reflected back to that port's acknowledge.

The block does not arbitrate. The environment must keep the two passive requests from being high together. It must also start a new request only after the previous cycle's acknowledge has returned low. The block records which port opened the current cycle and routes `c`'s acknowledge only to that port until the cycle closes. If both passive requests are seen high in the same clock cycle, a one-cycle protocol-error flag is raised and no cycle is started.

Top module: `hs_merge2`

## Requirements
- R1: After reset, `c_req`, `a_ack`, `b_ack` and `proto_err` are low and no port owns the merge, so the first request from either port is accepted.
- R2: From idle, a request that is high on `a_req` (or `b_req`) alone at a clock edge drives `c_req` high after that edge, and that port becomes the owner.
- R3: The owner's acknowledge rises on the edge after `c_ack` is seen high with `c_req` high, and never before `c_ack` has been seen high.
- R4: `c_req` falls on the edge after both passive requests are seen low while the owner's acknowledge is high; it is never lowered while either passive request is high, and the owner's acknowledge stays high meanwhile.
- R5: The owner's acknowledge falls on the edge after `c_ack` is seen low with `c_req` low; the merge is then idle and accepts a new request on the following edge.
- R6: The acknowledge of the port that does not own the current cycle stays low for the whole cycle, and the two acknowledges are never high together.
- R7: While idle, `c_ack` has no effect: `c_req`, `a_ack` and `b_ack` stay low.
- R8: `proto_err` is high for the cycle after an edge at which `a_req` and `b_req` are both high and low otherwise; such a collision from idle starts no cycle on `c`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Request of passive port a |
| a_ack | output | 1 | Acknowledge to passive port a |
| b_req | input | 1 | Request of passive port b |
| b_ack | output | 1 | Acknowledge to passive port b |
| c_req | output | 1 | Request of the shared active port c |
| c_ack | input | 1 | Acknowledge from the shared active port c |
| proto_err | output | 1 | One-cycle flag: both passive requests seen high together |

## Verification
The assertions assume a well-behaved environment. The two passive requests are never high together outside a deliberate collision. A port raises a new request only after its previous acknowledge has returned low, and it holds its request until acknowledged. The side of `c` follows the four-phase order. The stimulus keeps to these rules by construction. Each random cycle picks a port and four random phase delays and walks the full handshake, so the next request never begins before the previous acknowledge is low. The single collision case is driven from idle and is cleared before any other traffic.

// File: rtl/hs_merge2_pkg.sv
package hs_merge2_pkg;

    localparam int unsigned NPORT = 2;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e             owner;
        logic               creq;
        logic [NPORT-1:0]   ack;
        logic               err;
    } merge_state_t;

endpackage

// File: rtl/hs_merge2_lane.sv
module hs_merge2_lane (
    input  logic req,
    input  logic other_req,
    input  logic idle,
    input  logic owned,
    input  logic creq_q,
    input  logic ack_q,
    input  logic c_ack,
    output logic claim,
    output logic ack_d
);
    // A lane may claim the shared port only when the merge is idle and
    // its neighbour is quiet; a collision is left to the exclusion check.
    always_comb begin
        claim = idle && req && !other_req;
        if (!owned) begin
            ack_d = 1'b0;
        end else if (ack_q) begin
            ack_d = !((!creq_q) && (!c_ack));
        end else begin
            ack_d = creq_q && c_ack;
        end
    end
endmodule

// File: rtl/hs_merge2_excl.sv
module hs_merge2_excl #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] req,
    output logic         collide
);
    always_comb collide = ($countones(req) > 1);
endmodule

// File: rtl/hs_merge2.sv
module hs_merge2
    import hs_merge2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_req,
    output logic a_ack,
    input  logic b_req,
    output logic b_ack,
    output logic c_req,
    input  logic c_ack,
    output logic proto_err
);
    merge_state_t       st_d, st_q;
    logic [NPORT-1:0]   req_v;
    logic [NPORT-1:0]   claim_v;
    logic [NPORT-1:0]   ack_nx;
    logic [NPORT-1:0]   owned_v;
    logic               idle;
    logic               collide;
    logic               own_idx;

    assign req_v   = {b_req, a_req};
    assign idle    = (st_q.owner == OWN_NONE);
    assign own_idx = (st_q.owner == OWN_B);

    for (genvar i = 0; i < NPORT; i++) begin : g_lane
        assign owned_v[i] = (st_q.owner == ((i == 0) ? OWN_A : OWN_B));
        hs_merge2_lane u_lane (
            .req       (req_v[i]),
            .other_req (req_v[NPORT-1-i]),
            .idle      (idle),
            .owned     (owned_v[i]),
            .creq_q    (st_q.creq),
            .ack_q     (st_q.ack[i]),
            .c_ack     (c_ack),
            .claim     (claim_v[i]),
            .ack_d     (ack_nx[i])
        );
    end

    hs_merge2_excl #(.N(NPORT)) u_excl (
        .req     (req_v),
        .collide (collide)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = collide;
        st_d.ack = ack_nx;
        if (idle) begin
            if (claim_v[0]) begin
                st_d.owner = OWN_A;
                st_d.creq  = 1'b1;
            end else if (claim_v[1]) begin
                st_d.owner = OWN_B;
                st_d.creq  = 1'b1;
            end
        end else begin
            if (st_q.creq && st_q.ack[own_idx] && (req_v == '0)) begin
                st_d.creq = 1'b0;
            end
            if (st_q.ack[own_idx] && !ack_nx[own_idx]) begin
                st_d.owner = OWN_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, creq: 1'b0, ack: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign c_req     = st_q.creq;
    assign a_ack     = st_q.ack[0];
    assign b_ack     = st_q.ack[1];
    assign proto_err = st_q.err;

    AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ack && b_ack)); // R6
    AST_A_ACK_RISE_AFTER_C: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ack) |-> $past(c_ack)); // R3
    AST_B_ACK_RISE_AFTER_C: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_ack) |-> $past(c_ack)); // R3
    AST_CREQ_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_req) |-> $past(!a_req && !b_req)); // R4
    AST_A_ACK_FALL_AFTER_C: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_ack) |-> $past(!c_ack && !c_req)); // R5
    AST_B_ACK_FALL_AFTER_C: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_ack) |-> $past(!c_ack && !c_req)); // R5
    AST_ERR_ON_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(a_req && b_req)); // R8
    AST_CREQ_RISE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_req) |-> $past(a_req ^ b_req)); // R2
endmodule

// File: tb/sim_hs_merge2.sv
module sim_hs_merge2;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_req = 1'b0, b_req = 1'b0, c_ack = 1'b0;
    logic a_ack, b_ack, c_req, proto_err;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;

    always #4 clk = ~clk;

    hs_merge2 u0 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_ack(a_ack),
        .b_req(b_req), .b_ack(b_ack),
        .c_req(c_req), .c_ack(c_ack),
        .proto_err(proto_err)
    );

    // Phase of one merged cycle: 0 idle, 1 requested, 2 acknowledged,
    // 3 released, 4 returned to zero.
    function automatic bit exp_creq(int ph);
        return (ph == 1) || (ph == 2);
    endfunction

    function automatic bit exp_ack(int ph);
        return (ph == 2) || (ph == 3);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic set_req(bit sel, bit v);
        if (sel) b_req = v; else a_req = v;
    endtask

    task automatic step(bit sel, int ph, string tag);
        @(negedge clk);
        chk({tag, " c_req"}, c_req, exp_creq(ph));
        chk({tag, " owner ack"}, sel ? b_ack : a_ack, exp_ack(ph));
        chk("R6 other ack", sel ? a_ack : b_ack, 1'b0);
        chk("R8 no error", proto_err, 1'b0);
    endtask

    task automatic run_cycle(bit sel, int d1, int d2, int d3, int d4);
        set_req(sel, 1'b1);
        step(sel, 1, "R2");
        repeat (d1) step(sel, 1, "R3 wait");
        c_ack = 1'b1;
        step(sel, 2, "R3");
        repeat (d2) step(sel, 2, "R4 hold");
        set_req(sel, 1'b0);
        step(sel, 3, "R4");
        repeat (d3) step(sel, 3, "R5 wait");
        c_ack = 1'b0;
        step(sel, 4, "R5");
        repeat (d4) step(sel, 4, "R5 idle");
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a7e));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 c_req", c_req, 1'b0);
        chk("R1 a_ack", a_ack, 1'b0);
        chk("R1 b_ack", b_ack, 1'b0);
        chk("R1 proto_err", proto_err, 1'b0);

        // Directed: zero-delay cycles on each port, b first after reset.
        run_cycle(1'b1, 0, 0, 0, 0);
        run_cycle(1'b0, 0, 0, 0, 0);
        run_cycle(1'b0, 2, 1, 3, 1);

        // R7: c_ack while idle is ignored.
        c_ack = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R7 c_req", c_req, 1'b0);
            chk("R7 a_ack", a_ack, 1'b0);
            chk("R7 b_ack", b_ack, 1'b0);
        end
        c_ack = 1'b0;
        @(negedge clk);

        // R8: collision from idle flags an error and starts nothing.
        a_req = 1'b1;
        b_req = 1'b1;
        @(negedge clk);
        chk("R8 err high", proto_err, 1'b1);
        chk("R8 no c_req", c_req, 1'b0);
        a_req = 1'b0;
        b_req = 1'b0;
        @(negedge clk);
        chk("R8 err clears", proto_err, 1'b0);
        chk("R8 still idle", c_req, 1'b0);

        // Constrained random alternation with random phase delays.
        for (int k = 0; k < 300; k++) begin
            run_cycle(1'($urandom % 2), int'($urandom % 5), int'($urandom % 5),
                      int'($urandom % 5), int'($urandom % 4));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule